// File: doc/BRIEF.md
# Debug JTAG Port Control Register Bank

This block is the register bank of a debug access port that steers up to eight multiplexed JTAG target ports. A debug host reaches it over a 32-bit word bus with a select, a write strobe, a byte address and a ready return. The bank holds three registers: a control word, a port-select mask and a sticky port-loss record. The JTAG shift engine and its byte FIFOs live outside. The bank only observes their status (engine busy, bytes waiting in each FIFO) and folds it into the control word.

Software picks target ports through the select mask. A port is driven only when it is both picked and reports itself connected. The control word gives two summary flags: whether every picked port is connected, and whether every picked port carries its own system-reset strap. It also holds two levels that drive the TAP reset and the system reset; each stays in place until software changes it. The loss record catches any cycle in which a picked, connected port goes disabled or unpowered, so a glitch that is over before software looks is still seen. Software clears the record by writing ones.

A change of port selection while the engine is busy or write bytes are still queued would corrupt a scan. Such a write is therefore refused, and a sticky error output flags the refusal until a later write is accepted.

Top module: `jtp_port_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the select mask, the loss record, both reset levels and the error flag are all 0. With all inputs at 0, every register reads 0.
- R2: The control word at offset 0x00 reads ser_active in bit 31, wfifo_cnt in bits 30:28 and rfifo_cnt in bits 26:24. Bit 27 and bits 23:4 read 0.
- R3: Control bit 3 is 1 only when at least one port is selected and every selected port has port_conn high. Control bit 2 is 1 only when at least one port is selected and every selected port has port_srst_conn high. Both bits read 0 when no port is selected.
- R4: A write to offset 0x00 loads wdata bit 1 into trst_out and wdata bit 0 into srst_out on the next edge. Both read back in control bits 1:0 and keep their value until the next write to offset 0x00.
- R5: Offset 0x04 holds the 8-bit select mask in bits 7:0, loaded from wdata bits 7:0. Bits 31:8 read 0. port_enable equals the mask ANDed with port_conn.
- R6: A write to offset 0x04 while ser_active is 1 or wfifo_cnt is nonzero leaves the mask unchanged and sets sel_err on the next edge. An accepted write to offset 0x04 clears sel_err.
- R7: Offset 0x08 holds the loss record in bits 7:0, with bits 31:8 reading 0. Bit i becomes 1 at the edge after any cycle in which port i is selected, has port_conn high and has port_en low. A port that is unselected or unconnected never sets its bit.
- R8: A write to offset 0x08 clears each record bit whose wdata bit is 1 and leaves the bits with wdata 0 unchanged. If a port loss is seen in the same cycle as its clear, the bit stays 1.
- R9: bus_ready equals bus_sel in the same cycle, and read data is valid in that cycle. Addresses other than 0x00, 0x04 and 0x08 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_ready | output | 1 | Access completes this cycle |
| ser_active | input | 1 | JTAG shift engine is busy |
| wfifo_cnt | input | 3 | Bytes waiting in the write FIFO |
| rfifo_cnt | input | 3 | Bytes waiting in the read FIFO |
| port_conn | input | 8 | Per-port connected flag |
| port_srst_conn | input | 8 | Per-port strap: target has its own system reset |
| port_en | input | 8 | Per-port enabled and powered flag |
| port_enable | output | 8 | Per-port drive enable (selected and connected) |
| sel_err | output | 1 | Sticky flag: a select write was refused |
| trst_out | output | 1 | TAP reset level |
| srst_out | output | 1 | System reset level |

## Verification
On every cycle, assertions check that the reset levels hold between control writes, that a refused select write leaves the mask alone and raises the error flag, that a port loss always lands in the record, that record bits never drop without a record write, that the summary flags read 0 with an empty mask, and that no unconnected port is driven. The bench has to show the rest by scenario: the exact field layout of each register as read, the AND across a mixed selection, a clear that collides with a fresh loss, a write of zeros to the record, accesses to unmapped addresses, and the error flag clearing after a later accepted write. A cycle-level model in the bench checks all outputs over long random runs.

// File: rtl/jtp_pkg.sv
// Shared constants of the debug JTAG port register bank.
// Assumes byte addressing of 32-bit registers on the debug bus.
package jtp_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_PSEL = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;

    // control word field positions (software visible)
    localparam int CW_BUSY    = 31;
    localparam int CW_WCNT_LO = 28;
    localparam int CW_RCNT_LO = 24;
    localparam int CW_CONN    = 3;
    localparam int CW_SRSTC   = 2;
    localparam int CW_TRST    = 1;
    localparam int CW_SRST    = 0;
    localparam int CNT_W      = 3;
endpackage

// File: rtl/jtp_bus_dec.sv
// Address decoder: turns a bus access into one read hit and one write
// strobe per register. Assumes a single-cycle access and no byte lanes.
module jtp_bus_dec #(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit_ctrl,
    output logic              hit_psel,
    output logic              hit_stat,
    output logic              wr_ctrl,
    output logic              wr_psel,
    output logic              wr_stat
);
    import jtp_pkg::*;

    // compare the address with each register offset
    always_comb begin
        hit_ctrl = bus_sel && (bus_addr == ADDR_W'(OFS_CTRL));
        hit_psel = bus_sel && (bus_addr == ADDR_W'(OFS_PSEL));
        hit_stat = bus_sel && (bus_addr == ADDR_W'(OFS_STAT));
    end

    // qualify hits with the write strobe
    always_comb begin
        wr_ctrl = hit_ctrl && bus_wr;
        wr_psel = hit_psel && bus_wr;
        wr_stat = hit_stat && bus_wr;
    end
endmodule

// File: rtl/jtp_port_sel.sv
// Port select mask with write guard, drive enables and AND summary flags.
// Assumes the serializer status inputs are synchronous to clk.
module jtp_port_sel #(
    parameter int NPORTS = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_psel,
    input  logic [NPORTS-1:0] wmask,
    input  logic              ser_active,
    input  logic [CNT_W-1:0]  wfifo_cnt,
    input  logic [NPORTS-1:0] port_conn,
    input  logic [NPORTS-1:0] port_srst_conn,
    output logic [NPORTS-1:0] psel_q,
    output logic [NPORTS-1:0] port_enable,
    output logic              sel_err,
    output logic              all_conn,
    output logic              all_srst
);
    logic busy;
    logic [NPORTS-1:0] conn_ok;
    logic [NPORTS-1:0] srst_ok;

    // engine is unsafe to re-target while shifting or with queued bytes
    always_comb busy = ser_active || (wfifo_cnt != '0);

    // select mask and refusal flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel_q  <= '0;
            sel_err <= 1'b0;
        end else if (wr_psel) begin
            if (busy) begin
                sel_err <= 1'b1;
            end else begin
                psel_q  <= wmask;
                sel_err <= 1'b0;
            end
        end
    end

    // per-port enable and "don't care when unselected" terms
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        always_comb begin
            port_enable[i] = psel_q[i] & port_conn[i];
            conn_ok[i]     = port_conn[i] | ~psel_q[i];
            srst_ok[i]     = port_srst_conn[i] | ~psel_q[i];
        end
    end

    // summary flags are 0 when nothing is selected
    always_comb begin
        all_conn = (|psel_q) && (&conn_ok);
        all_srst = (|psel_q) && (&srst_ok);
    end

    // R6: refused write keeps the mask and raises the flag
    a_r6_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_psel && (ser_active || wfifo_cnt != '0)) |=> ($stable(psel_q) && sel_err));
endmodule

// File: rtl/jtp_port_status.sv
// Sticky per-port loss record, sampled every cycle, cleared by writing ones.
// Assumes port_en is synchronous to clk; a new loss wins over a clear.
module jtp_port_status #(
    parameter int NPORTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] psel_q,
    input  logic [NPORTS-1:0] port_conn,
    input  logic [NPORTS-1:0] port_en,
    input  logic              wr_stat,
    input  logic [NPORTS-1:0] clr_mask,
    output logic [NPORTS-1:0] psta_q
);
    logic [NPORTS-1:0] loss;
    logic [NPORTS-1:0] clr;

    // a selected, connected port that is disabled counts as lost
    always_comb begin
        loss = psel_q & port_conn & ~port_en;
        clr  = wr_stat ? clr_mask : '0;
    end

    // record update per port
    for (genvar i = 0; i < NPORTS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)       psta_q[i] <= 1'b0;
            else if (loss[i]) psta_q[i] <= 1'b1;
            else if (clr[i])  psta_q[i] <= 1'b0;
        end
    end

    // R7: every observed loss appears in the record
    a_r7_loss_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (|loss) |=> ((psta_q & $past(loss)) == $past(loss)));

    // R8: without a record write, no bit falls
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat) |=> ((psta_q & $past(psta_q)) == $past(psta_q)));
endmodule

// File: rtl/jtp_port_ctl.sv
// Top of the debug JTAG port register bank: control word with reset
// levels, port select and loss record on a single-cycle word bus.
// Assumes every access completes in its own cycle (ready = select).
module jtp_port_ctl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NPORTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              ser_active,
    input  logic [2:0]        wfifo_cnt,
    input  logic [2:0]        rfifo_cnt,
    input  logic [NPORTS-1:0] port_conn,
    input  logic [NPORTS-1:0] port_srst_conn,
    input  logic [NPORTS-1:0] port_en,
    output logic [NPORTS-1:0] port_enable,
    output logic              sel_err,
    output logic              trst_out,
    output logic              srst_out
);
    import jtp_pkg::*;

    logic hit_ctrl, hit_psel, hit_stat;
    logic wr_ctrl, wr_psel, wr_stat;
    logic [NPORTS-1:0] psel_q, psta_q;
    logic all_conn, all_srst;
    logic trst_q, srst_q;
    logic [DATA_W-1:0] ctrl_word;

    jtp_bus_dec #(.ADDR_W(ADDR_W)) i_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .hit_ctrl(hit_ctrl),
        .hit_psel(hit_psel),
        .hit_stat(hit_stat),
        .wr_ctrl (wr_ctrl),
        .wr_psel (wr_psel),
        .wr_stat (wr_stat)
    );

    jtp_port_sel #(.NPORTS(NPORTS), .CNT_W(CNT_W)) i_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_psel       (wr_psel),
        .wmask         (bus_wdata[NPORTS-1:0]),
        .ser_active    (ser_active),
        .wfifo_cnt     (wfifo_cnt),
        .port_conn     (port_conn),
        .port_srst_conn(port_srst_conn),
        .psel_q        (psel_q),
        .port_enable   (port_enable),
        .sel_err       (sel_err),
        .all_conn      (all_conn),
        .all_srst      (all_srst)
    );

    jtp_port_status #(.NPORTS(NPORTS)) i_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel_q   (psel_q),
        .port_conn(port_conn),
        .port_en  (port_en),
        .wr_stat  (wr_stat),
        .clr_mask (bus_wdata[NPORTS-1:0]),
        .psta_q   (psta_q)
    );

    // reset levels, held until software rewrites them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trst_q <= 1'b0;
            srst_q <= 1'b0;
        end else if (wr_ctrl) begin
            trst_q <= bus_wdata[CW_TRST];
            srst_q <= bus_wdata[CW_SRST];
        end
    end

    // assemble the control word from status and local state
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CW_BUSY]                       = ser_active;
        ctrl_word[CW_WCNT_LO +: CNT_W]           = wfifo_cnt;
        ctrl_word[CW_RCNT_LO +: CNT_W]           = rfifo_cnt;
        ctrl_word[CW_CONN]                       = all_conn;
        ctrl_word[CW_SRSTC]                      = all_srst;
        ctrl_word[CW_TRST]                       = trst_q;
        ctrl_word[CW_SRST]                       = srst_q;
    end

    // read multiplexer; unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata = ctrl_word;
        else if (hit_psel) bus_rdata = DATA_W'(psel_q);
        else if (hit_stat) bus_rdata = DATA_W'(psta_q);
    end

    // single-cycle completion and output drive
    always_comb begin
        bus_ready = bus_sel;
        trst_out  = trst_q;
        srst_out  = srst_q;
    end

    // R4: reset levels move only on a control write
    a_r4_levels_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctrl) |=> $stable({trst_out, srst_out}));

    // R3: summary flags read 0 with an empty mask
    a_r3_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctrl && psel_q == '0) |-> (bus_rdata[CW_CONN:CW_SRSTC] == 2'b00));

    // R5: an unconnected port is never driven
    a_r5_enable_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_enable & ~port_conn) == '0));
endmodule

// File: tb/test_jtp_port_ctl.sv
`timescale 1ns/100ps
module test_jtp_port_ctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        ser_active;
    logic [2:0]  wfifo_cnt, rfifo_cnt;
    logic [7:0]  port_conn, port_srst_conn, port_en, port_enable;
    logic        sel_err, trst_out, srst_out;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_psel, m_psta;
    logic       m_trst, m_srst, m_err;

    always #2 clk = ~clk;

    jtp_port_ctl i_jtp_port_ctl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .ser_active(ser_active), .wfifo_cnt(wfifo_cnt),
        .rfifo_cnt(rfifo_cnt), .port_conn(port_conn), .port_srst_conn(port_srst_conn),
        .port_en(port_en), .port_enable(port_enable), .sel_err(sel_err),
        .trst_out(trst_out), .srst_out(srst_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] w;
        w = '0;
        case (a)
            8'h00: begin
                w[31]    = ser_active;
                w[30:28] = wfifo_cnt;
                w[26:24] = rfifo_cnt;
                w[3]     = (m_psel != 0) && ((port_conn & m_psel) == m_psel);
                w[2]     = (m_psel != 0) && ((port_srst_conn & m_psel) == m_psel);
                w[1]     = m_trst;
                w[0]     = m_srst;
            end
            8'h04:   w[7:0] = m_psel;
            8'h08:   w[7:0] = m_psta;
            default: w = '0;
        endcase
        return w;
    endfunction

    // one bus cycle: drive, check at mid-cycle, advance the reference, clock
    task automatic step(input logic s, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        logic [7:0] loss;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        chk("R9 ready", {31'b0, bus_ready}, {31'b0, s});
        if (s && !w) chk(tag, bus_rdata, exp_read(a));
        chk("R4 levels", {30'b0, trst_out, srst_out}, {30'b0, m_trst, m_srst});
        chk("R5 enable", {24'b0, port_enable}, {24'b0, m_psel & port_conn});
        chk("R6 err", {31'b0, sel_err}, {31'b0, m_err});
        loss = m_psel & port_conn & ~port_en;
        if (s && w && a == 8'h08) m_psta = (m_psta & ~d[7:0]) | loss;
        else                      m_psta = m_psta | loss;
        if (s && w && a == 8'h00) begin m_trst = d[1]; m_srst = d[0]; end
        if (s && w && a == 8'h04) begin
            if (ser_active || wfifo_cnt != 0) m_err = 1'b1;
            else begin m_psel = d[7:0]; m_err = 1'b0; end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ser_active = 0; wfifo_cnt = 0; rfifo_cnt = 0;
        port_conn = 8'hFF; port_srst_conn = 8'hFF; port_en = 8'hFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] ad;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        ser_active = 0; wfifo_cnt = 0; rfifo_cnt = 0;
        port_conn = 0; port_srst_conn = 0; port_en = 0;
        m_psel = 0; m_psta = 0; m_trst = 0; m_srst = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state through every register
        step(1, 0, 8'h00, 0, "R1 ctrl");
        step(1, 0, 8'h04, 0, "R1 psel");
        step(1, 0, 8'h08, 0, "R1 stat");
        // R2: status fields in the control word
        ser_active = 1; wfifo_cnt = 3'd5; rfifo_cnt = 3'd6;
        step(1, 0, 8'h00, 0, "R2 fields");
        idle_inputs();
        // R4: reset levels set, held, cleared
        step(1, 1, 8'h00, 32'hFFFF_FFFF, "R4");
        step(0, 0, 8'h00, 0, "R4");
        step(1, 0, 8'h00, 0, "R4 readback");
        step(1, 1, 8'h00, 32'h0000_0002, "R4");
        step(1, 0, 8'h00, 0, "R4 trst only");
        step(1, 1, 8'h00, 0, "R4");
        // R5: select mask with upper bits dropped
        step(1, 1, 8'h04, 32'hFFFF_FF5A, "R5");
        step(1, 0, 8'h04, 0, "R5 mask read");
        // R3: AND across selected ports
        port_srst_conn = 8'h5A;
        step(1, 0, 8'h00, 0, "R3 all set");
        port_conn = 8'hF7;
        step(1, 0, 8'h00, 0, "R3 one missing");
        port_srst_conn = 8'h58;
        step(1, 0, 8'h00, 0, "R3 srst missing");
        idle_inputs();
        step(1, 1, 8'h04, 0, "R3");
        step(1, 0, 8'h00, 0, "R3 empty mask");
        // R6: refused select writes
        ser_active = 1;
        step(1, 1, 8'h04, 32'h01, "R6");
        step(1, 0, 8'h04, 0, "R6 busy kept");
        ser_active = 0; wfifo_cnt = 3'd2;
        step(1, 1, 8'h04, 32'h02, "R6");
        step(1, 0, 8'h04, 0, "R6 fifo kept");
        wfifo_cnt = 0;
        step(1, 1, 8'h04, 32'h0F, "R6");
        step(1, 0, 8'h04, 0, "R6 accepted");
        // R7: single-cycle loss, unselected and unconnected ports ignored
        port_en = 8'h7E; port_conn = 8'hFD;
        step(0, 0, 8'h00, 0, "R7");
        port_en = 8'hFD;
        step(0, 0, 8'h00, 0, "R7");
        idle_inputs();
        step(1, 0, 8'h08, 0, "R7 record");
        // R8: zero write, collision with loss, real clear
        step(1, 1, 8'h08, 0, "R8");
        step(1, 0, 8'h08, 0, "R8 zero write");
        port_en = 8'hFE;
        step(1, 1, 8'h08, 32'h01, "R8");
        idle_inputs();
        step(1, 0, 8'h08, 0, "R8 loss wins");
        step(1, 1, 8'h08, 32'hFF, "R8");
        step(1, 0, 8'h08, 0, "R8 cleared");
        // R9: unmapped address
        step(1, 1, 8'h0C, 32'hFFFF_FFFF, "R9");
        step(1, 0, 8'h0C, 0, "R9 unmapped read");
        step(1, 0, 8'h00, 0, "R9 ctrl unchanged");
        step(1, 0, 8'h04, 0, "R9 psel unchanged");
        // random phase
        for (int k = 0; k < 3000; k++) begin
            ser_active     = ($urandom_range(0, 3) == 0);
            wfifo_cnt      = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom);
            rfifo_cnt      = 3'($urandom);
            port_conn      = 8'($urandom) | 8'($urandom);
            port_srst_conn = 8'($urandom) | 8'($urandom);
            port_en        = 8'hFF & ~(8'(1) << $urandom_range(0, 15));
            case ($urandom_range(0, 4))
                0: ad = 8'h00;
                1: ad = 8'h04;
                2: ad = 8'h08;
                3: ad = 8'h0C;
                default: ad = 8'($urandom);
            endcase
            step($urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1, ad, $urandom,
                 "R2,R3,R5,R7 random read");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule